// File: doc/BRIEF.md
# Slot-Paced Video Write Queue

This block queues write requests for the memory port of a video controller. The CPU and the DMA engines push request descriptors. Each descriptor holds a write count and two mode flags: a byte-access flag and a DMA-fill flag. The queue holds descriptors, not data words. One memory access slot is spent on each `slot_tick` pulse. A word descriptor spends one slot per write. A byte descriptor spends two slots per write.

The block keeps a running total of the words still pending. It registers the empty and full levels from that total. It raises a CPU stall while a CPU write is waiting for room. A CPU write that arrives while a DMA fill sits at the head of the queue ends that fill at once: the fill's remaining slots are discarded and the fill-active status drops.

The descriptors sit in a small circular store, addressed by a head index and a length. A remaining-slot counter tracks the head descriptor. Everything runs on one clock with a synchronous active-high reset.

Top module: `vid_slot_wq`

## Requirements
- R1: The queue holds at most 8 descriptors. A push is accepted only when fewer than 8 descriptors remain after this cycle's pop. A rejected push leaves `total_pending` unchanged.
- R2: A push with a nonzero count is accepted under R1 and raises `total_pending` by the count. A push with count 0 has no effect at all.
- R3: For a word descriptor (`push_flags` bit 0 = 0), each slot tick lowers `total_pending` by 1.
- R4: A byte descriptor (`push_flags` bit 0 = 1) needs 2 × count slots. Slot ticks act on it in pairs. The first tick of a pair leaves `total_pending` unchanged and the second lowers it by 1.
- R5: Descriptors drain in push order, each in its own mode. The next descriptor takes the slot tick that follows the last slot of the one before.
- R6: A slot tick with an empty queue has no effect. When a push and a tick come in the same cycle, the tick acts on the queue as it was, and the push is applied afterwards. A push into an empty queue therefore keeps its full slot budget.
- R7: `empty` is 1 exactly when `total_pending` is 0. `full` is 1 exactly when `total_pending` is 4 or more. Both change in the same cycle as `total_pending`.
- R8: A write is a push with a nonzero count and `push_flags` bit 1 = 0. `cpu_stall` rises when a write arrives, `total_pending` is then 4 or more, and no DMA fill is active. It stays high until `total_pending` falls below 4 or a fill becomes active.
- R9: When a write arrives and the head descriptor has the DMA-fill flag (bit 1) set, all remaining slots of the head are consumed in that cycle. `total_pending` drops by the head's remaining words, and the write is then pushed if there is room.
- R10: `dma_fill_active` rises on an accepted push with bit 1 = 1. It falls on an abort as in R9, or when `total_pending` reaches 0.
- R11: A slot tick in the same cycle as an abort is taken up by the abort and is not applied to the next descriptor.
- R12: Reset gives `total_pending` = 0, `empty` = 1, `full` = 0, `cpu_stall` = 0 and `dma_fill_active` = 0, and empties the queue.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| push_valid | input | 1 | Push a request descriptor this cycle |
| push_count | input | CNT_W | Number of writes in the request |
| push_flags | input | 2 | Bit 1: DMA fill; bit 0: byte access |
| slot_tick | input | 1 | One pulse per memory access slot |
| total_pending | output | TOT_W | Words still pending across the queue |
| empty | output | 1 | No words pending |
| full | output | 1 | Pending words at or above the full level |
| cpu_stall | output | 1 | CPU write must wait for room |
| dma_fill_active | output | 1 | A DMA fill is queued and running |

## Verification
Word-only and byte-only runs on their own separate the one-slot and two-slot cost per write. Mixed descriptors show that the mode is taken per descriptor and that the head moves on at the right tick. Filling the queue to eight descriptors and past it checks that extra pushes are rejected and how the stall level rises and falls. Fill descriptors cut off by a write, both at the head and behind word descriptors, and with or without a tick in the same cycle, separate an abort from normal draining. A long stretch of random push, tick and flag patterns is compared against a scoreboard model on every cycle.

// File: rtl/vid_slot_wq_pkg.sv
package vid_slot_wq_pkg;
  // Each descriptor stores {count, flags}; these are the flag positions.
  localparam int FLAG_BYTE = 0;
  localparam int FLAG_FILL = 1;
  localparam int FLAG_W    = 2;
endpackage

// File: rtl/vid_slot_wq_store.sv
module vid_slot_wq_store #(
  parameter int DEPTH = 8,
  parameter int EW    = 18,
  localparam int AW   = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [EW-1:0] wdata,
  input  logic [AW-1:0] raddr_a,
  input  logic [AW-1:0] raddr_b,
  output logic [EW-1:0] rdata_a,
  output logic [EW-1:0] rdata_b
);
  // Small descriptor array: single write port, two asynchronous read ports.
  logic [EW-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
  end

  assign rdata_a = mem[raddr_a];
  assign rdata_b = mem[raddr_b];
endmodule

// File: rtl/vid_slot_wq_ctrl.sv
module vid_slot_wq_ctrl
  import vid_slot_wq_pkg::*;
#(
  parameter int DEPTH = 8,
  parameter int CNT_W = 16,
  localparam int AW    = $clog2(DEPTH),
  localparam int LEN_W = AW + 1,
  localparam int REM_W = CNT_W + 1,
  localparam int TOT_W = CNT_W + AW,
  localparam int EW    = CNT_W + FLAG_W
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             push_valid,
  input  logic [CNT_W-1:0] push_count,
  input  logic [1:0]       push_flags,
  input  logic             slot_tick,
  input  logic [EW-1:0]    head_ent,
  input  logic [EW-1:0]    next_ent,
  output logic             wr_en,
  output logic [AW-1:0]    wr_addr,
  output logic [EW-1:0]    wr_data,
  output logic [AW-1:0]    head_addr,
  output logic [AW-1:0]    next_addr,
  output logic [TOT_W-1:0] total_q,
  output logic [TOT_W-1:0] total_n,
  output logic             abort,
  output logic             fill_push,
  output logic             push_write
);
  logic [AW-1:0]    head_q, head_a;
  logic [LEN_W-1:0] len_q, len_a, len_n;
  logic [REM_W-1:0] rem_q, rem_a, rem_b, rem_n, consume;
  logic [REM_W:0]   drop;
  logic [TOT_W-1:0] total_a;
  logic             tick_use, pop, accept;

  function automatic logic [REM_W-1:0] slots_of(input logic [EW-1:0] ent);
    logic [REM_W-1:0] c;
    c = {1'b0, ent[EW-1:FLAG_W]};
    return ent[FLAG_BYTE] ? (c << 1) : c;
  endfunction

  always_comb begin
    push_write = push_valid && (push_count != '0) && !push_flags[FLAG_FILL];
    abort      = push_write && (len_q != '0) && head_ent[FLAG_FILL];
    tick_use   = slot_tick && (len_q != '0) && !abort;

    // Step 1: spend slots on the head (abort takes all that remain).
    if (abort)         consume = rem_q;
    else if (tick_use) consume = REM_W'(1);
    else               consume = '0;
    if (head_ent[FLAG_BYTE])
      drop = ({1'b0, consume} + (REM_W+1)'(rem_q[0])) >> 1;
    else
      drop = {1'b0, consume};
    rem_a   = rem_q - consume;
    total_a = total_q - TOT_W'(drop);
    pop     = (abort || tick_use) && (rem_a == '0);
    head_a  = head_q + AW'(pop);
    len_a   = len_q - LEN_W'(pop);
    if (pop) rem_b = (len_a != '0) ? slots_of(next_ent) : '0;
    else     rem_b = rem_a;

    // Step 2: append the new descriptor behind what is left.
    accept    = push_valid && (push_count != '0) && (len_a < LEN_W'(DEPTH));
    wr_en     = accept;
    wr_addr   = head_a + len_a[AW-1:0];
    wr_data   = {push_count, push_flags};
    len_n     = len_a + LEN_W'(accept);
    total_n   = total_a + (accept ? TOT_W'(push_count) : '0);
    rem_n     = (accept && (len_a == '0)) ? slots_of({push_count, push_flags}) : rem_b;
    fill_push = accept && push_flags[FLAG_FILL];
  end

  assign head_addr = head_q;
  assign next_addr = head_q + AW'(1);

  always_ff @(posedge clk) begin
    if (rst) begin
      head_q  <= '0;
      len_q   <= '0;
      rem_q   <= '0;
      total_q <= '0;
    end else begin
      head_q  <= head_a;
      len_q   <= len_n;
      rem_q   <= rem_n;
      total_q <= total_n;
    end
  end

  AST_LEN_BOUND: assert property (@(posedge clk) disable iff (rst)
    len_q <= LEN_W'(DEPTH)); // R1
  AST_FULL_HOLDS: assert property (@(posedge clk) disable iff (rst)
    (len_q == LEN_W'(DEPTH) && !slot_tick && !abort) |=> (len_q == LEN_W'(DEPTH))); // R1
  AST_TOTAL_TRACKS_LEN: assert property (@(posedge clk) disable iff (rst)
    (total_q == '0) == (len_q == '0)); // R5
  AST_HEAD_HAS_SLOTS: assert property (@(posedge clk) disable iff (rst)
    (len_q != '0) |-> (rem_q != '0)); // R5
  AST_WORD_STEP: assert property (@(posedge clk) disable iff (rst)
    (slot_tick && len_q != '0 && !head_ent[FLAG_BYTE] && !push_valid)
      |=> (total_q == $past(total_q) - TOT_W'(1))); // R3
endmodule

// File: rtl/vid_slot_wq_status.sv
module vid_slot_wq_status #(
  parameter int TOT_W    = 19,
  parameter int FULL_LVL = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [TOT_W-1:0] total_n,
  input  logic             fill_push,
  input  logic             abort,
  input  logic             push_write,
  output logic             empty,
  output logic             full,
  output logic             cpu_stall,
  output logic             dma_fill_active
);
  logic fill_n, stall_n, full_n;

  always_comb begin
    full_n = total_n >= TOT_W'(FULL_LVL);
    if (fill_push)                        fill_n = 1'b1;
    else if (abort || total_n == '0)      fill_n = 1'b0;
    else                                  fill_n = dma_fill_active;
    stall_n = full_n && !fill_n && (cpu_stall || push_write);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      empty           <= 1'b1;
      full            <= 1'b0;
      cpu_stall       <= 1'b0;
      dma_fill_active <= 1'b0;
    end else begin
      empty           <= (total_n == '0);
      full            <= full_n;
      cpu_stall       <= stall_n;
      dma_fill_active <= fill_n;
    end
  end

  AST_LEVELS_EXCL: assert property (@(posedge clk) disable iff (rst)
    !(empty && full)); // R7
  AST_STALL_GATED: assert property (@(posedge clk) disable iff (rst)
    cpu_stall |-> (full && !dma_fill_active)); // R8
  AST_ABORT_CLEARS_FILL: assert property (@(posedge clk) disable iff (rst)
    abort |=> !dma_fill_active); // R9
endmodule

// File: rtl/vid_slot_wq.sv
module vid_slot_wq
  import vid_slot_wq_pkg::*;
#(
  parameter int DEPTH    = 8,
  parameter int CNT_W    = 16,
  parameter int FULL_LVL = 4,
  localparam int TOT_W   = CNT_W + $clog2(DEPTH)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             push_valid,
  input  logic [CNT_W-1:0] push_count,
  input  logic [1:0]       push_flags,
  input  logic             slot_tick,
  output logic [TOT_W-1:0] total_pending,
  output logic             empty,
  output logic             full,
  output logic             cpu_stall,
  output logic             dma_fill_active
);
  localparam int AW = $clog2(DEPTH);
  localparam int EW = CNT_W + FLAG_W;

  logic          wr_en, abort, fill_push, push_write;
  logic [AW-1:0] wr_addr, head_addr, next_addr;
  logic [EW-1:0] wr_data, head_ent, next_ent;
  logic [TOT_W-1:0] total_n;

  vid_slot_wq_store #(.DEPTH(DEPTH), .EW(EW)) u_store (
    .clk(clk), .we(wr_en), .waddr(wr_addr), .wdata(wr_data),
    .raddr_a(head_addr), .raddr_b(next_addr),
    .rdata_a(head_ent), .rdata_b(next_ent)
  );

  vid_slot_wq_ctrl #(.DEPTH(DEPTH), .CNT_W(CNT_W)) u_ctrl (
    .clk(clk), .rst(rst), .push_valid(push_valid), .push_count(push_count),
    .push_flags(push_flags), .slot_tick(slot_tick),
    .head_ent(head_ent), .next_ent(next_ent),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .head_addr(head_addr), .next_addr(next_addr),
    .total_q(total_pending), .total_n(total_n),
    .abort(abort), .fill_push(fill_push), .push_write(push_write)
  );

  vid_slot_wq_status #(.TOT_W(TOT_W), .FULL_LVL(FULL_LVL)) u_status (
    .clk(clk), .rst(rst), .total_n(total_n), .fill_push(fill_push),
    .abort(abort), .push_write(push_write),
    .empty(empty), .full(full), .cpu_stall(cpu_stall),
    .dma_fill_active(dma_fill_active)
  );
endmodule

// File: tb/vid_slot_wq_bench.sv
`timescale 1ns/1ps
module vid_slot_wq_bench;
  localparam int CNT_W = 16;
  localparam int TOT_W = 19;

  logic clk = 1'b0, rst = 1'b1;
  logic push_valid = 1'b0, slot_tick = 1'b0;
  logic [CNT_W-1:0] push_count = '0;
  logic [1:0] push_flags = '0;
  logic [TOT_W-1:0] total_pending;
  logic empty, full, cpu_stall, dma_fill_active;

  always #2.5 clk = ~clk;

  vid_slot_wq u_vid_slot_wq (
    .clk(clk), .rst(rst), .push_valid(push_valid), .push_count(push_count),
    .push_flags(push_flags), .slot_tick(slot_tick),
    .total_pending(total_pending), .empty(empty), .full(full),
    .cpu_stall(cpu_stall), .dma_fill_active(dma_fill_active)
  );

  typedef struct { int total; bit emp; bit ful; bit stall; bit fill; string req; } exp_t;
  exp_t expq[$];

  // Reference model state, built from the requirements.
  int  m_cnt[$];
  bit  m_byte[$], m_fill[$];
  int  m_rem = 0, m_total = 0;
  bit  m_fa = 0, m_st = 0;
  int  n_vec = 0, n_bad = 0;
  bit  finished = 0;

  task automatic check(string req, string what, int act, int exp);
    n_vec++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  function automatic int slots(int c, bit b);
    return b ? 2 * c : c;
  endfunction

  task automatic step(bit pv, int cnt, bit [1:0] fl, bit tk, string req);
    bit wr, ab, tu, acc;
    int cons, drop;
    exp_t e;
    @(negedge clk);
    push_valid = pv; push_count = CNT_W'(cnt); push_flags = fl; slot_tick = tk;
    wr = pv && cnt != 0 && !fl[1];
    ab = wr && m_cnt.size() != 0 && m_fill[0];                 // R9
    tu = tk && m_cnt.size() != 0 && !ab;                       // R6 R11
    if (ab || tu) begin
      cons = ab ? m_rem : 1;
      drop = m_byte[0] ? (cons + (m_rem % 2)) / 2 : cons;      // R3 R4
      m_total -= drop; m_rem -= cons;
      if (m_rem == 0) begin
        void'(m_cnt.pop_front()); void'(m_byte.pop_front()); void'(m_fill.pop_front());
        if (m_cnt.size() != 0) m_rem = slots(m_cnt[0], m_byte[0]);   // R5
      end
    end
    acc = pv && cnt != 0 && m_cnt.size() < 8;                  // R1 R2
    if (acc) begin
      m_cnt.push_back(cnt); m_byte.push_back(fl[0]); m_fill.push_back(fl[1]);
      m_total += cnt;
      if (m_cnt.size() == 1) m_rem = slots(cnt, fl[0]);
    end
    if (acc && fl[1]) m_fa = 1;                                // R10
    else if (ab || m_total == 0) m_fa = 0;
    m_st = (m_total >= 4) && !m_fa && (m_st || wr);            // R8
    e.total = m_total; e.emp = (m_total == 0); e.ful = (m_total >= 4);
    e.stall = m_st; e.fill = m_fa; e.req = req;
    expq.push_back(e);
  endtask

  task automatic idle(int n, bit tk, string req);
    for (int i = 0; i < n; i++) step(0, 0, 2'b00, tk, req);
  endtask

  // Scoreboard monitor: compare one expected item after each edge.
  always @(posedge clk) begin
    #1;
    if (expq.size() != 0) begin
      exp_t e;
      e = expq.pop_front();
      check(e.req, "total_pending", int'(total_pending), e.total);
      check("R7", "empty", int'(empty), int'(e.emp));
      check("R7", "full", int'(full), int'(e.ful));
      check("R8", "cpu_stall", int'(cpu_stall), int'(e.stall));
      check("R10", "dma_fill_active", int'(dma_fill_active), int'(e.fill));
    end
  end

  initial begin
    #(5.0 * 50000);
    if (!finished) begin
      n_bad++;
      $display("FAIL watchdog expired");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    @(posedge clk); #1;
    check("R12", "total_pending", int'(total_pending), 0);
    check("R12", "empty", int'(empty), 1);
    check("R12", "full/stall/fill", int'({full, cpu_stall, dma_fill_active}), 0);
    @(negedge clk); rst = 1'b0;

    step(1, 3, 2'b00, 0, "R2");        // word push
    idle(4, 1, "R3");                  // last tick hits an empty queue (R6)
    step(1, 0, 2'b00, 1, "R2");        // zero count ignored
    step(1, 2, 2'b01, 0, "R4");        // byte push
    idle(5, 1, "R4");
    step(1, 2, 2'b00, 1, "R6");        // push with tick on empty queue
    idle(3, 1, "R6");
    step(1, 2, 2'b00, 0, "R5");
    step(1, 1, 2'b01, 0, "R5");
    step(1, 1, 2'b00, 0, "R5");
    idle(6, 1, "R5");
    for (int i = 0; i < 9; i++) step(1, 1, 2'b00, 0, "R1");   // ninth is rejected
    @(posedge clk); #1;
    check("R1", "total after overfill", int'(total_pending), 8);
    check("R8", "stall while full", int'(cpu_stall), 1);
    idle(9, 1, "R8");
    step(1, 10, 2'b10, 0, "R10");      // fill, no stall while active
    idle(2, 1, "R10");
    step(1, 1, 2'b00, 0, "R9");        // write aborts fill
    @(posedge clk); #1;
    check("R9", "total after abort", int'(total_pending), 1);
    idle(2, 1, "R9");
    step(1, 5, 2'b11, 0, "R9");        // byte fill
    idle(3, 1, "R9");
    step(1, 2, 2'b01, 0, "R9");
    idle(5, 1, "R9");
    step(1, 6, 2'b10, 0, "R11");
    step(1, 3, 2'b00, 1, "R11");       // abort and tick together
    idle(4, 1, "R11");
    step(1, 2, 2'b00, 0, "R9");        // fill queued behind a word entry
    step(1, 5, 2'b10, 0, "R9");
    step(1, 1, 2'b00, 0, "R9");        // head is a word: no abort
    idle(3, 1, "R9");
    step(1, 1, 2'b00, 0, "R9");        // head is now the fill: abort
    idle(4, 1, "R9");
    for (int i = 0; i < 500; i++) begin
      bit pv, tk; int c; bit [1:0] f;
      pv = ($urandom % 3) == 0;
      c  = $urandom % 6;
      f  = 2'($urandom % 4);
      if (($urandom % 3) != 0) f[1] = 1'b0;
      tk = ($urandom % 2) == 0;
      step(pv, c, f, tk, "R5");
    end
    idle(2, 0, "R6");
    @(negedge clk);
    finished = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule